// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

This block is a watchdog counter that advances on a strobe from a dedicated slow oscillator, already brought into the system clock domain. When the count reaches the period chosen by a 4-bit prescaler code, the watchdog times out. Depending on two enable bits, a time-out raises an interrupt flag, pulses a system reset output, or first raises the flag and then resets on the following time-out if software has not recovered. A restart strobe, driven when software issues its watchdog-kick instruction, returns the count to zero.

All control lives in one 8-bit control/status register, reached through a simple write strobe and a combinational read port. The reset enable and the prescaler code are guarded by a small state machine. A write that sets the change-enable bit and the reset-enable bit together moves it from `WIN_LOCKED` to `WIN_OPEN`. While it is open, the next write replaces the reset-enable bit and the prescaler code and takes the machine back to `WIN_LOCKED`. The window also closes by itself when it expires. The interrupt flag clears when the interrupt is acknowledged or when software writes a one to it.

The time-out action depends on the pair {reset enable, interrupt enable}: `MODE_OFF` (counter held at zero), `MODE_IRQ`, `MODE_RST` and `MODE_BOTH`. In `MODE_BOTH`, a time-out sets only the flag. Acknowledging that interrupt clears the interrupt-enable bit, which moves the block to `MODE_RST`.

Top module: `wdog_guard`

## Requirements
- R1: After reset the register reads all zeros except bit 3, which takes the value of `wde_init`. `irq` and `wdt_rst` are low.
- R2: Register bit positions are: 7 time-out flag, 6 interrupt enable, 5 prescaler code bit 3, 4 change enable (window open), 3 reset enable, 2..0 prescaler code bits 2..0.
- R3: A write with bits 4 and 3 both 1 while locked opens the window. Bit 4 then reads 1 for exactly 4 cycles (`WIN_CYCLES`). A write that lands in any of those 4 cycles loads bit 3 and the prescaler code from the data and closes the window at once.
- R4: While the window is closed, writes cannot change the prescaler code and cannot clear bit 3, but a written 1 always sets bit 3.
- R5: With the counter restarted, prescaler code n (0 to 9) gives a time-out on the 2^(BASE_LOG2+n)-th tick. Codes 10 to 15 behave as code 9. BASE_LOG2 defaults to 11 (2K ticks).
- R6: In `MODE_IRQ` a time-out sets the flag, and `irq` equals flag AND interrupt enable AND `gie`.
- R7: The flag clears on `irq_ack` or on a write with bit 7 = 1. A write with bit 7 = 0 leaves it unchanged, and a time-out in the same cycle wins over a clear. An acknowledge leaves bit 6 unchanged when bit 3 is 0.
- R8: In `MODE_RST` a time-out drives `wdt_rst` high for exactly one cycle and does not set the flag. The counter then wraps to zero, so pulses repeat every period.
- R9: In `MODE_BOTH` a time-out sets the flag without a reset. `irq_ack` then clears both the flag and bit 6, so the next time-out pulses `wdt_rst`.
- R10: `restart` clears the counter, and no time-out occurs at the edge where it is sampled.
- R11: In `MODE_OFF` the counter is held at zero, so after enabling a mode the first time-out comes a full period later.
- R12: The terminal check compares the count with the current code's period and fires when the count is at or above it. Switching to a shorter period with a larger count already present times out on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wde_init | input | 1 | Reset value of the reset-enable bit |
| osc_tick | input | 1 | One-cycle strobe from the watchdog oscillator |
| restart | input | 1 | Watchdog kick: clears the counter |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| irq_ack | input | 1 | Interrupt acknowledge from the interrupt controller |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Watchdog interrupt request |
| wdt_rst | output | 1 | One-cycle system reset request |

## Verification
On every cycle the assertions hold the guard rules: the window never stays open longer than its limit, the prescaler code and a set reset-enable bit stay fixed while it is locked, a reset pulse lasts one cycle and needs reset-enable, the flag cannot vanish without a clear, and a restart blocks a reset. The exact time-out cycle for each prescaler code, the exact edge on which the window closes, the hand-over from interrupt to reset in the combined mode, the immediate time-out after shortening the period and the full-period delay after leaving the stopped mode depend on multi-step sequences. Only the bench's directed scenarios show these.

// File: rtl/wdog_guard_pkg.sv
package wdog_guard_pkg;

    localparam int CODE_W  = 4;
    localparam int REG_W   = 8;

    // register bit positions (software decodes these)
    localparam int B_FLAG  = 7;
    localparam int B_IEN   = 6;
    localparam int B_CODE3 = 5;
    localparam int B_CHG   = 4;
    localparam int B_REN   = 3;

    typedef enum logic {
        WIN_LOCKED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_t;

    // encoding is {reset enable, interrupt enable}
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_IRQ  = 2'b01,
        MODE_RST  = 2'b10,
        MODE_BOTH = 2'b11
    } wd_mode_t;

endpackage

// File: rtl/wdog_unlock_fsm.sv
module wdog_unlock_fsm
    import wdog_guard_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic unlock_req,
    output logic win_open,
    output logic win_grant
);

    localparam int LEFT_W = $clog2(WIN_CYCLES + 1);

    win_state_t        state_q, state_d;
    logic [LEFT_W-1:0] left_q, left_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            WIN_LOCKED: begin
                if (wr_en && unlock_req) begin
                    state_d = WIN_OPEN;
                    left_d  = LEFT_W'(WIN_CYCLES);
                end
            end
            WIN_OPEN: begin
                if (wr_en) begin
                    state_d = WIN_LOCKED;
                    left_d  = '0;
                end else if (left_q <= LEFT_W'(1)) begin
                    state_d = WIN_LOCKED;
                    left_d  = '0;
                end else begin
                    left_d  = left_q - LEFT_W'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_LOCKED;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // outputs
    always_comb begin
        win_open  = (state_q == WIN_OPEN);
        win_grant = wr_en && (state_q == WIN_OPEN);
    end

endmodule

// File: rtl/wdog_period_sel.sv
module wdog_period_sel
    import wdog_guard_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9,
    parameter int CNT_W     = BASE_LOG2 + MAX_CODE + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  term
);

    localparam int N_CODES = 1 << CODE_W;

    logic [CNT_W-1:0] term_lut [N_CODES];

    for (genvar i = 0; i < N_CODES; i++) begin : g_term
        localparam int SHIFT = BASE_LOG2 + ((i > MAX_CODE) ? MAX_CODE : i);
        assign term_lut[i] = CNT_W'((64'd1 << SHIFT) - 64'd1);
    end

    assign term = term_lut[code];

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] term,
    output logic             timeout
);

    logic [CNT_W-1:0] cnt_q;

    assign timeout = run && tick && !restart && (cnt_q >= term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (timeout) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_guard_pkg::*;
#(
    parameter int BASE_LOG2  = 11,
    parameter int MAX_CODE   = 9,
    parameter int WIN_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wde_init,
    input  logic             osc_tick,
    input  logic             restart,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             irq_ack,
    input  logic             gie,
    output logic             irq,
    output logic             wdt_rst
);

    localparam int CNT_W = BASE_LOG2 + MAX_CODE + 1;

    logic              flag_q, ien_q, ren_q, rst_q;
    logic [CODE_W-1:0] code_q;
    logic              win_open, win_grant, unlock_req;
    logic [CNT_W-1:0]  term;
    logic              timeout, run;
    logic              flag_set, rst_fire, flag_clr;
    logic [CODE_W-1:0] wr_code;
    wd_mode_t          mode;

    assign unlock_req = wr_data[B_CHG] && wr_data[B_REN];
    assign wr_code    = {wr_data[B_CODE3], wr_data[2:0]};

    wdog_unlock_fsm #(
        .WIN_CYCLES (WIN_CYCLES)
    ) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .unlock_req (unlock_req),
        .win_open   (win_open),
        .win_grant  (win_grant)
    );

    wdog_period_sel #(
        .BASE_LOG2 (BASE_LOG2),
        .MAX_CODE  (MAX_CODE),
        .CNT_W     (CNT_W)
    ) u_period (
        .code (code_q),
        .term (term)
    );

    assign mode = wd_mode_t'({ren_q, ien_q});
    assign run  = (mode != MODE_OFF);

    wdog_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (osc_tick),
        .term    (term),
        .timeout (timeout)
    );

    // time-out action per mode
    always_comb begin
        flag_set = 1'b0;
        rst_fire = 1'b0;
        unique case (mode)
            MODE_OFF:  ;
            MODE_IRQ:  flag_set = timeout;
            MODE_RST:  rst_fire = timeout;
            MODE_BOTH: flag_set = timeout;
        endcase
    end

    assign flag_clr = irq_ack || (wr_en && wr_data[B_FLAG]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
            ren_q  <= wde_init;
            code_q <= '0;
            rst_q  <= 1'b0;
        end else begin
            rst_q <= rst_fire;
            if (flag_set) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
            if (irq_ack && ren_q) begin
                ien_q <= 1'b0;
            end else if (wr_en) begin
                ien_q <= wr_data[B_IEN];
            end
            if (win_grant) begin
                ren_q  <= wr_data[B_REN];
                code_q <= wr_code;
            end else if (wr_en && wr_data[B_REN]) begin
                ren_q  <= 1'b1;
            end
        end
    end

    assign rd_data = {flag_q, ien_q, code_q[3], win_open, ren_q, code_q[2:0]};
    assign irq     = flag_q && ien_q && gie;
    assign wdt_rst = rst_q;

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
    parameter int WIN_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       wr_en,
    input logic       wr_flag,
    input logic [7:0] rd_data,
    input logic       irq_ack,
    input logic       wdt_rst
);

    localparam int RUN_W = $clog2(WIN_CYCLES + 2);

    logic [RUN_W-1:0] open_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_run <= '0;
        end else if (rd_data[4]) begin
            if (open_run != '1) begin
                open_run <= open_run + RUN_W'(1);
            end
        end else begin
            open_run <= '0;
        end
    end

    AST_WIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> (open_run < RUN_W'(WIN_CYCLES))); // R3

    AST_LOCKED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[4] |=> ($stable(rd_data[5]) && $stable(rd_data[2:0]))); // R4

    AST_REN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[4] && rd_data[3]) |=> rd_data[3]); // R4

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !irq_ack && !(wr_en && wr_flag)) |=> rd_data[7]); // R7

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst); // R8

    AST_RST_NEEDS_REN: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> $past(rd_data[3])); // R8

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !wdt_rst); // R10

endmodule

bind wdog_guard wdog_guard_chk #(
    .WIN_CYCLES (WIN_CYCLES)
) u_wdog_guard_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .wr_en   (wr_en),
    .wr_flag (wr_data[7]),
    .rd_data (rd_data),
    .irq_ack (irq_ack),
    .wdt_rst (wdt_rst)
);

// File: tb/test_wdog_guard.sv
module test_wdog_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wde_init = 1'b0;
    logic       osc_tick = 1'b1;
    logic       restart = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_ack = 1'b0;
    logic       gie = 1'b1;
    logic       irq;
    logic       wdt_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdog_guard #(
        .BASE_LOG2  (3),
        .MAX_CODE   (9),
        .WIN_CYCLES (4)
    ) i_wdog_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .wde_init (wde_init),
        .osc_tick (osc_tick),
        .restart  (restart),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_ack  (irq_ack),
        .gie      (gie),
        .irq      (irq),
        .wdt_rst  (wdt_rst)
    );

    // prescaler code vs expected period with BASE_LOG2 = 3 (R5)
    localparam int NVEC = 7;
    localparam logic [3:0] VCODE [NVEC] = '{4'd0, 4'd1, 4'd2, 4'd5, 4'd9, 4'd10, 4'd15};
    localparam int         VPER  [NVEC] = '{8, 16, 32, 256, 4096, 4096, 4096};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic kick_wr(input logic [7:0] d);
        restart = 1'b1;
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        restart = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input bit on_rst, output int n);
        n = 0;
        while (!(on_rst ? wdt_rst : rd_data[7]) && n < 6000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        bit seen;
        idle(3);
        // R1: reset state
        chk("R1 rd_data", 32'(rd_data), 32'h00);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 wdt_rst", 32'(wdt_rst), 32'd0);
        rst_n = 1'b1;
        idle(50);
        chk("R11 no flag when stopped", 32'(rd_data[7]), 32'd0);

        // R11/R6: enable interrupt mode, first time-out one full period later
        wr(8'h40);
        idle(7);
        chk("R11 no early timeout", 32'(rd_data[7]), 32'd0);
        idle(1);
        chk("R6 flag on timeout", 32'(rd_data[7]), 32'd1);
        chk("R6 irq with gie", 32'(irq), 32'd1);
        gie = 1'b0;
        #1;
        chk("R6 irq gated by gie", 32'(irq), 32'd0);
        gie = 1'b1;

        // R7: flag clearing
        wr(8'h40);
        chk("R7 write zero keeps flag", 32'(rd_data[7]), 32'd1);
        wr(8'hC0);
        chk("R7 write one clears flag", 32'(rd_data[7]), 32'd0);
        idle(6);
        chk("R6 periodic flag", 32'(rd_data[7]), 32'd1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R7 ack clears flag, keeps enable", 32'(rd_data), 32'h40);

        // R4/R2: locked writes
        wr(8'h48);
        chk("R4 set reset enable without unlock", 32'(rd_data & 8'h7F), 32'h48);
        wr(8'h47);
        chk("R4 locked code/clear ignored", 32'(rd_data & 8'h7F), 32'h48);
        wr(8'h68);
        chk("R4 locked code bit3 ignored", 32'(rd_data & 8'h7F), 32'h48);

        // R3: window length
        wr(8'h18);
        chk("R3 window visible", 32'(rd_data & 8'h7F), 32'h18);
        idle(3);
        chk("R3 window open 4th cycle", 32'(rd_data[4]), 32'd1);
        idle(1);
        chk("R3 window closed after 4", 32'(rd_data[4]), 32'd0);
        wr(8'h01);
        chk("R4 late write rejected", 32'(rd_data & 8'h7F), 32'h08);
        wr(8'h18);
        idle(3);
        wr(8'h02);
        chk("R3 write on last window cycle", 32'(rd_data & 8'h7F), 32'h02);
        wr(8'h18);
        wr(8'h20);
        chk("R2 code bit3 position", 32'(rd_data & 8'h7F), 32'h20);
        wr(8'h80);
        chk("R7 clear in stopped mode", 32'(rd_data), 32'h20);

        // R5: period table walk in interrupt mode
        for (int v = 0; v < NVEC; v++) begin
            wr(8'h58);
            wr({1'b0, 1'b1, VCODE[v][3], 2'b00, VCODE[v][2:0]});
            kick_wr(8'hC0);
            measure(1'b0, n);
            chk($sformatf("R5 period code %0d", VCODE[v]), 32'(n), 32'(VPER[v]));
        end

        // R12: shortening the period with a large count
        wr(8'h58);
        wr(8'h45);
        kick_wr(8'hC0);
        idle(40);
        chk("R12 no flag before shorten", 32'(rd_data[7]), 32'd0);
        wr(8'h58);
        wr(8'h40);
        chk("R12 no flag at switch edge", 32'(rd_data[7]), 32'd0);
        idle(1);
        chk("R12 immediate timeout", 32'(rd_data[7]), 32'd1);

        // R8: reset mode
        wr(8'h18);
        wr(8'h08);
        kick_wr(8'h88);
        measure(1'b1, n);
        chk("R8 reset after period", 32'(n), 32'd8);
        chk("R8 no flag in reset mode", 32'(rd_data[7]), 32'd0);
        idle(1);
        chk("R8 reset one cycle", 32'(wdt_rst), 32'd0);
        measure(1'b1, n);
        chk("R8 wrap repeats period", 32'(n), 32'd7);

        // R10: regular restarts prevent reset
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            restart = 1'b1;
            @(negedge clk);
            restart = 1'b0;
            if (wdt_rst) seen = 1'b1;
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                if (wdt_rst) seen = 1'b1;
            end
        end
        chk("R10 restart keeps reset away", 32'(seen), 32'd0);

        // R9: interrupt then reset
        wr(8'h58);
        wr(8'h48);
        kick_wr(8'hC8);
        measure(1'b0, n);
        chk("R9 flag after period", 32'(n), 32'd8);
        chk("R9 no reset on first timeout", 32'(wdt_rst), 32'd0);
        chk("R9 irq raised", 32'(irq), 32'd1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R9 ack clears flag and enable", 32'(rd_data), 32'h08);
        measure(1'b1, n);
        chk("R9 reset on next timeout", 32'(n), 32'd7);
        chk("R9 no flag with reset", 32'(rd_data[7]), 32'd0);

        finish_run();
    end

endmodule